// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencing Controller

This block is the state machine that sequences a multi-cycle processor datapath. It takes the 6-bit opcode held in the instruction register and a flag that says whether the two register operands are equal. Every cycle it drives the datapath's register load enables, multiplexer selects, ALU operation code and memory strobes.

Each instruction starts with an instruction fetch cycle and a decode/register-read cycle. After that, it follows only the path its class needs:

- Branches and jumps finish in their third cycle.
- Stores and register-to-register ALU operations finish in their fourth cycle.
- Loads finish in their fifth cycle.
- An opcode the controller does not recognise sends it straight back to fetch after decode.

All outputs are decoded from the current state. The one exception is the PC load in the branch state, which also depends on the equality flag.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: An active-low asynchronous reset forces the fetch state, whether or not an instruction is in progress. In fetch the controller asserts the following and nothing else:
  - `pc_load`=1 with `pc_src`=00 (PC from the ALU result);
  - `ir_we`=1;
  - `mem_rd`=1 with `addr_sel`=0 (address from PC);
  - `alu_a_sel`=0 (PC);
  - `alu_b_sel`=01 (constant 4);
  - `alu_op`=00 (add).
- R2: The cycle after fetch is always decode, for every opcode. In decode the controller asserts the following and nothing else:
  - `ab_we`=1 and `aluout_we`=1;
  - `alu_a_sel`=0;
  - `alu_b_sel`=11 (shifted sign-extended immediate);
  - `alu_op`=00.
- R3: Opcode 100011 (load) takes 5 cycles in total. After decode come three states:
  - Address generation: `aluout_we`=1, `alu_a_sel`=1 (A), `alu_b_sel`=10 (sign-extended immediate), `alu_op`=00.
  - Memory read: `mem_rd`=1, `addr_sel`=1 (ALUOut), `mdr_we`=1.
  - Writeback: `rf_we`=1, `rf_dst_sel`=0 (rt field), `rf_data_sel`=1 (MDR).
- R4: Opcode 101011 (store) takes 4 cycles. After decode come two states:
  - Address generation, the same as in R3.
  - Memory write: `mem_wr`=1 and `addr_sel`=1 only.
- R5: Opcode 000000 (register ALU operation) takes 4 cycles. After decode come two states:
  - Execute: `aluout_we`=1, `alu_a_sel`=1, `alu_b_sel`=00 (B), `alu_op`=10 (function field).
  - Writeback: `rf_we`=1, `rf_dst_sel`=1 (rd field), `rf_data_sel`=0 (ALUOut).
- R6: Opcode 000100 (branch if equal) takes 3 cycles. Its third state drives `pc_src`=01 (ALUOut), `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=01 (subtract). In that state `pc_load` equals `a_eq_b`.
- R7: Opcode 000010 (jump) takes 3 cycles. Its third state drives only `pc_load`=1 and `pc_src`=10 (jump target).
- R8: Any other opcode makes the controller return to fetch on the clock that ends decode, so the instruction takes 2 cycles.
- R9: Every completion state returns to fetch on the next clock. The following enables are each active only in their own states:
  - register-file write;
  - memory write;
  - instruction-register write;
  - MDR load;
  - operand-register load.

  `mem_rd` and `mem_wr` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| a_eq_b | input | 1 | Operand A equals operand B |
| pc_load | output | 1 | Load the PC |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALUOut, 10 jump target |
| ir_we | output | 1 | Instruction register load |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALUOut |
| ab_we | output | 1 | Load operand registers A and B |
| aluout_we | output | 1 | Load ALUOut |
| mdr_we | output | 1 | Load memory data register |
| rf_we | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination: 0 rt field, 1 rd field |
| rf_data_sel | output | 1 | Write data: 0 ALUOut, 1 MDR |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 A |
| alu_b_sel | output | 2 | ALU B input: 00 B, 01 four, 10 immediate, 11 immediate shifted by 2 |
| alu_op | output | 2 | ALU control: 00 add, 01 subtract, 10 function field |

## Verification
The outputs are a pure decode of the state register. A wrong state therefore shows up on the control word in the same cycle, as enables asserted in the wrong place or as a missing strobe. A wrong transition shows up one clock later, as a control word that does not match the expected step of the instruction. An instruction of the wrong length appears at the first cycle where the bench expects fetch and sees something else, or the reverse. The branch condition is visible in the same cycle that `a_eq_b` is driven.

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm #(
  parameter logic [5:0] OP_RTYPE = 6'b000000,
  parameter logic [5:0] OP_LOAD  = 6'b100011,
  parameter logic [5:0] OP_STORE = 6'b101011,
  parameter logic [5:0] OP_BEQ   = 6'b000100,
  parameter logic [5:0] OP_JUMP  = 6'b000010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic       a_eq_b,
  output logic       pc_load,
  output logic [1:0] pc_src,
  output logic       ir_we,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       addr_sel,
  output logic       ab_we,
  output logic       aluout_we,
  output logic       mdr_we,
  output logic       rf_we,
  output logic       rf_dst_sel,
  output logic       rf_data_sel,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_op
);

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_LDMEM, S_LDWB,
    S_STMEM, S_REXE, S_RWB, S_BEQ, S_JMP
  } state_t;

  state_t st, st_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_FETCH;
    else        st <= st_nx;

  always_comb begin
    case (st)
      S_FETCH:  st_nx = S_DECODE;
      S_DECODE: begin
        if (opcode == OP_LOAD || opcode == OP_STORE) st_nx = S_ADDR;
        else if (opcode == OP_RTYPE)                 st_nx = S_REXE;
        else if (opcode == OP_BEQ)                   st_nx = S_BEQ;
        else if (opcode == OP_JUMP)                  st_nx = S_JMP;
        else                                         st_nx = S_FETCH;
      end
      S_ADDR:   st_nx = (opcode == OP_LOAD) ? S_LDMEM : S_STMEM;
      S_LDMEM:  st_nx = S_LDWB;
      S_REXE:   st_nx = S_RWB;
      default:  st_nx = S_FETCH;
    endcase
  end

  wire in_fetch = st == S_FETCH;
  wire in_dec   = st == S_DECODE;
  wire in_addr  = st == S_ADDR;
  wire in_ldmem = st == S_LDMEM;
  wire in_ldwb  = st == S_LDWB;
  wire in_stmem = st == S_STMEM;
  wire in_rexe  = st == S_REXE;
  wire in_rwb   = st == S_RWB;
  wire in_beq   = st == S_BEQ;
  wire in_jmp   = st == S_JMP;

  assign pc_load     = in_fetch | in_jmp | (in_beq & a_eq_b);
  assign pc_src      = in_jmp ? 2'b10 : (in_beq ? 2'b01 : 2'b00);
  assign ir_we       = in_fetch;
  assign mem_rd      = in_fetch | in_ldmem;
  assign mem_wr      = in_stmem;
  assign addr_sel    = in_ldmem | in_stmem;
  assign ab_we       = in_dec;
  assign aluout_we   = in_dec | in_addr | in_rexe;
  assign mdr_we      = in_ldmem;
  assign rf_we       = in_ldwb | in_rwb;
  assign rf_dst_sel  = in_rwb;
  assign rf_data_sel = in_ldwb;
  assign alu_a_sel   = in_addr | in_rexe | in_beq;
  assign alu_b_sel   = in_fetch ? 2'b01 : in_dec ? 2'b11 : in_addr ? 2'b10 : 2'b00;
  assign alu_op      = in_rexe ? 2'b10 : (in_beq ? 2'b01 : 2'b00);

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       a_eq_b,
  input logic       pc_load,
  input logic [1:0] pc_src,
  input logic       ir_we,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       addr_sel,
  input logic       ab_we,
  input logic       mdr_we,
  input logic       rf_we,
  input logic       rf_data_sel
);

  p_mem_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_we_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ir_we, rf_we, mem_wr, ab_we, mdr_we}));

  p_decode_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |=> (ab_we && !ir_we));

  p_load_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mdr_we |=> (rf_we && rf_data_sel));

  p_store_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (addr_sel && !mem_rd));

  p_beq_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && pc_src == 2'b01) |-> a_eq_b);

  p_return_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || mem_wr || (pc_load && pc_src != 2'b00)) |=> ir_we);

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .a_eq_b(a_eq_b), .pc_load(pc_load),
  .pc_src(pc_src), .ir_we(ir_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .addr_sel(addr_sel), .ab_we(ab_we), .mdr_we(mdr_we), .rf_we(rf_we),
  .rf_data_sel(rf_data_sel)
);

// File: tb/tb_mc_ctrl_fsm.sv
module tb_mc_ctrl_fsm;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, a_eq_b = 0;
  logic [5:0] opcode = 0;
  logic pc_load, ir_we, mem_rd, mem_wr, addr_sel, ab_we, aluout_we, mdr_we;
  logic rf_we, rf_dst_sel, rf_data_sel, alu_a_sel;
  logic [1:0] pc_src, alu_b_sel, alu_op;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_ctrl_fsm dut (.*);

  wire [17:0] word = {pc_load, pc_src, ir_we, mem_rd, mem_wr, addr_sel, ab_we,
                      aluout_we, mdr_we, rf_we, rf_dst_sel, rf_data_sel,
                      alu_a_sel, alu_b_sel, alu_op};

  // class: 0 rtype, 1 load, 2 store, 3 beq, 4 jump, 5 unknown
  function automatic int cls_of(input logic [5:0] op);
    case (op)
      6'b000000: return 0;
      6'b100011: return 1;
      6'b101011: return 2;
      6'b000100: return 3;
      6'b000010: return 4;
      default:   return 5;
    endcase
  endfunction

  function automatic int len_of(input int c);
    case (c)
      0: return 4; 1: return 5; 2: return 4;
      3: return 3; 4: return 3; default: return 2;
    endcase
  endfunction

  function automatic logic [17:0] mk(input logic pl, input logic [1:0] ps,
      input logic ir, input logic mr, input logic mw, input logic as,
      input logic ab, input logic ao, input logic md, input logic rw,
      input logic rd, input logic rs, input logic aa, input logic [1:0] bb,
      input logic [1:0] op);
    return {pl, ps, ir, mr, mw, as, ab, ao, md, rw, rd, rs, aa, bb, op};
  endfunction

  function automatic logic [17:0] fetch_w();
    return mk(1, 2'b00, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b01, 2'b00);
  endfunction

  function automatic logic [17:0] exp_w(input int c, input int step, input logic eq);
    logic [17:0] addr_w;
    addr_w = mk(0, 2'b00, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 2'b10, 2'b00);
    if (step == 0) return fetch_w();
    if (step == 1) return mk(0, 2'b00, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 2'b11, 2'b00);
    case (c)
      0: return (step == 2) ? mk(0, 2'b00, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 2'b00, 2'b10)
                            : mk(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 2'b00, 2'b00);
      1: return (step == 2) ? addr_w :
                (step == 3) ? mk(0, 2'b00, 0, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 2'b00, 2'b00)
                            : mk(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 2'b00, 2'b00);
      2: return (step == 2) ? addr_w
                            : mk(0, 2'b00, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
      3: return mk(eq, 2'b01, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b01);
      default: return mk(1, 2'b10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
    endcase
  endfunction

  function automatic string tag_of(input int c, input int step, input logic after_done);
    if (step == 0) return after_done ? "R9" : "R1";
    if (step == 1) return (c == 5) ? "R8" : "R2";
    case (c)
      0: return "R5"; 1: return "R3"; 2: return "R4";
      3: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [17:0] exp);
    checks++;
    if (word !== exp) begin
      failures++;
      $display("FAIL %s: control word got %b expected %b", tag, word, exp);
    end
  endtask

  logic done_flag = 0;

  // drives one instruction starting in fetch; inputs at negedge, check 1 time unit later
  task automatic run_instr(input logic [5:0] op, input int eq_mode, input int stop_at);
    int c = cls_of(op);
    int n = len_of(c);
    for (int s = 0; s < n; s++) begin
      if (s == stop_at) return;
      if (s == 0) opcode = op;
      a_eq_b = (eq_mode == 2) ? 1'($urandom_range(0, 1)) : 1'(eq_mode);
      #1;
      check(tag_of(c, s, done_flag), exp_w(c, s, a_eq_b));
      if (c == 3 && s == 2) begin
        checks++;
        if (pc_load !== a_eq_b) begin
          failures++;
          $display("FAIL R6: pc_load got %b expected %b", pc_load, a_eq_b);
        end
      end
      @(negedge clk);
    end
    done_flag = 1;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [5:0] ops[5];
    void'($urandom(32'd1234));
    ops[0] = 6'b000000; ops[1] = 6'b100011; ops[2] = 6'b101011;
    ops[3] = 6'b000100; ops[4] = 6'b000010;
    opcode = 6'b100011;
    repeat (3) @(negedge clk);
    #1 check("R1", fetch_w());
    @(negedge clk);
    rst_n = 1;

    // directed: each class, both branch outcomes, unknown opcodes
    run_instr(6'b100011, 0, -1);
    run_instr(6'b101011, 0, -1);
    run_instr(6'b000000, 0, -1);
    run_instr(6'b000100, 1, -1);
    run_instr(6'b000100, 0, -1);
    run_instr(6'b000010, 1, -1);
    run_instr(6'b111111, 0, -1);
    run_instr(6'b100011, 1, -1);
    run_instr(6'b000001, 1, -1);

    // R1: reset in the middle of a load returns to fetch
    run_instr(6'b100011, 0, 3);
    rst_n = 0;
    #1 check("R1", fetch_w());
    @(negedge clk);
    rst_n = 1;
    done_flag = 0;
    run_instr(6'b000000, 0, -1);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [5:0] op;
      if ($urandom_range(0, 9) < 8) op = ops[$urandom_range(0, 4)];
      else op = 6'($urandom);
      run_instr(op, 2, -1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule